// File: doc/BRIEF.md
# Source-Selectable Rate Divider

This block produces a one-cycle enable strobe from one of four incoming enable strobes. Everything runs in a single system clock domain. A 32-bit control word chooses the source and sets the divide ratio. One of the four sources passes through an extra pre-divide stage before it reaches the shared post-divider. The other three feed the post-divider directly. The output strobe has the rate of the chosen source, divided by the pre-divide ratio when that stage is in use, and then by the post-divide ratio.

The control word is written through a write port with a per-bit mask, so software can change one field without touching the others. The whole word can be read back at any time. A write that changes any functional field restarts the divide chain. No partial period can then produce an early strobe.

Top module: `cdiv_top`

## Requirements
- R1: After reset the control word reads 0. That selects source 0 with an overall ratio of 1, so `tickOut` follows `srcTick[0]` in every cycle that has no write.
- R2: Bits [17:16] of the control word give the source index. Only strobes on `srcTick[index]` are counted, and strobes on the other three sources have no effect on `tickOut`.
- R3: Bits [5:4] hold the post-divide field. The post-divide ratio is the field value plus one, which gives 1 to 4.
- R4: Bits [12:8] hold the pre-divide field. Its ratio is the field value plus one (1 to 32), and it applies only when bits [17:16] equal 3.
- R5: When the source index is 0, 1 or 2, the pre-divide field has no effect on the output rate.
- R6: With source 3 selected, `tickOut` fires on every (pre+1)*(post+1)-th selected strobe, counted from the last restart.
- R7: A write replaces only the control bits whose `cfgWrMask` bit is 1. All other bits keep their value, and `cfgRdData` shows the updated word from the next cycle.
- R8: Bits outside [17:16], [12:8] and [5:4] read back as written. Writing only those bits neither restarts the divide chain nor changes the output.
- R9: A write whose mask touches any functional field restarts the divide chain. `tickOut` is 0 in the write cycle. The first strobe under the new setting comes on the ratio-th selected strobe after that cycle.
- R10: `tickOut` is one system clock wide. It is high only in a cycle where the selected source strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 4 | Source enable strobes, one per selectable source |
| cfgWe | input | 1 | Control word write enable |
| cfgWrData | input | 32 | Write data |
| cfgWrMask | input | 32 | Per-bit write mask, 1 = replace bit |
| cfgRdData | output | 32 | Current control word |
| tickOut | output | 1 | Divided enable strobe |

## Verification
A counter that skips or sticks shows up at `tickOut` as a strobe in the wrong slot. The error appears within one full divide period, at most 128 selected strobes. A counter that is not cleared on a restart breaks the spacing of the first strobe after the write. A wrong source decode makes strobes appear in cycles where the selected source is low, and this is visible at once. The bench samples every cycle against a running count of selected strobes, so each of these faults is caught in the cycle it first affects.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int SRC_N   = 4;
  localparam int SEL_W   = $clog2(SRC_N);
  localparam int PRE_W   = 5;
  localparam int POST_W  = 2;
  localparam int WORD_W  = 32;
  localparam int SEL_LSB  = 16;
  localparam int PRE_LSB  = 8;
  localparam int POST_LSB = 4;
  localparam int PRE_SRC  = 3;

  // Strobes and limits handed from control to datapath
  typedef struct packed {
    logic              reload;
    logic [SEL_W-1:0]  sel;
    logic              preOn;
    logic [PRE_W-1:0]  preLim;
    logic [POST_W-1:0] postLim;
  } divCtrlT;
endpackage

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic [WORD_W-1:0] cfgWrMask,
  output logic [WORD_W-1:0] cfgRdData,
  output divCtrlT           ctrl
);
  localparam logic [WORD_W-1:0] SEL_MASK  = WORD_W'(((1 << SEL_W) - 1) << SEL_LSB);
  localparam logic [WORD_W-1:0] PRE_MASK  = WORD_W'(((1 << PRE_W) - 1) << PRE_LSB);
  localparam logic [WORD_W-1:0] POST_MASK = WORD_W'(((1 << POST_W) - 1) << POST_LSB);
  localparam logic [WORD_W-1:0] FIELD_MASK = SEL_MASK | PRE_MASK | POST_MASK;

  logic [WORD_W-1:0] cfgWord;
  logic [WORD_W-1:0] nextWord;

  always_comb nextWord = (cfgWord & ~cfgWrMask) | (cfgWrData & cfgWrMask);

  always_ff @(posedge clk) begin
    if (!rstN)      cfgWord <= '0;
    else if (cfgWe) cfgWord <= nextWord;
  end

  assign cfgRdData = cfgWord;

  always_comb begin
    ctrl.reload  = cfgWe && ((cfgWrMask & FIELD_MASK) != '0);
    ctrl.sel     = cfgWord[SEL_LSB +: SEL_W];
    ctrl.preOn   = (cfgWord[SEL_LSB +: SEL_W] == SEL_W'(PRE_SRC));
    ctrl.preLim  = cfgWord[PRE_LSB +: PRE_W];
    ctrl.postLim = cfgWord[POST_LSB +: POST_W];
  end

  // R7: with no write the readback word holds
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgRdData));
  // R8: writes confined to unused bits never restart the chain
  a_r8_unused_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && ((cfgWrMask & FIELD_MASK) == '0)) |-> !ctrl.reload);
endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] srcTick,
  input  divCtrlT          ctrl,
  output logic             tickOut
);
  logic [SRC_N-1:0]  srcHit;
  logic              selTick;
  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic              preDone;
  logic              postDone;

  for (genvar i = 0; i < SRC_N; i++) begin : g_pick
    assign srcHit[i] = srcTick[i] && (ctrl.sel == SEL_W'(i));
  end

  assign selTick = |srcHit;

  always_comb begin
    preDone  = selTick && (!ctrl.preOn || (preCnt == ctrl.preLim));
    postDone = preDone && (postCnt == ctrl.postLim);
    tickOut  = postDone && !ctrl.reload;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.reload) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else begin
      if (selTick && ctrl.preOn)
        preCnt <= preDone ? '0 : preCnt + 1'b1;
      if (preDone)
        postCnt <= postDone ? '0 : postCnt + 1'b1;
    end
  end

  // R10: an output strobe always coincides with a selected source strobe
  a_r10_tick_on_source: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> srcTick[ctrl.sel]);
  // R9: no output in a restart cycle
  a_r9_quiet_on_reload: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.reload |-> !tickOut);
  // R6: counters never pass their limits
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= ctrl.preLim);
  a_r3_post_bound: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= ctrl.postLim);
  // R5: pre counter idle while a direct source is chosen
  a_r5_pre_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.preOn |-> preCnt == '0);
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcTick,
  input  logic              cfgWe,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic [WORD_W-1:0] cfgWrMask,
  output logic [WORD_W-1:0] cfgRdData,
  output logic              tickOut
);
  divCtrlT ctrl;

  cdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .cfgWrMask(cfgWrMask), .cfgRdData(cfgRdData), .ctrl(ctrl)
  );

  cdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .ctrl(ctrl), .tickOut(tickOut)
  );
endmodule

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  srcTick = '0;
  logic        cfgWe = 0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgWrMask = '0;
  logic [31:0] cfgRdData;
  logic        tickOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cdiv_top u0 (.clk(clk), .rstN(rstN), .srcTick(srcTick), .cfgWe(cfgWe),
    .cfgWrData(cfgWrData), .cfgWrMask(cfgWrMask), .cfgRdData(cfgRdData),
    .tickOut(tickOut));

  // each entry {sel[1:0], pre[4:0], post[1:0]}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    {2'd0, 5'd0,  2'd0}, {2'd0, 5'd0,  2'd3}, {2'd1, 5'd9, 2'd1},
    {2'd2, 5'd31, 2'd2}, {2'd3, 5'd0,  2'd0}, {2'd3, 5'd4, 2'd0},
    {2'd3, 5'd2,  2'd2}, {2'd3, 5'd31, 2'd3}, {2'd3, 5'd5, 2'd1},
    {2'd1, 5'd0,  2'd3}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [31:0] d, logic [31:0] m, logic [3:0] t,
                          logic expTick, string req);
    @(negedge clk);
    cfgWe = 1; cfgWrData = d; cfgWrMask = m; srcTick = t;
    #1 check(req, {31'd0, tickOut}, {31'd0, expTick});
    @(negedge clk);
    cfgWe = 0; cfgWrMask = '0; srcTick = '0;
  endtask

  // Drive n cycles; selected source toggles by pattern, others always high.
  // cnt is the count of selected strobes since the last restart.
  task automatic run(int sel, int ratio, int n, ref int cnt, input string req);
    for (int c = 0; c < n; c++) begin
      logic s;
      s = ((c * 7 + 3) % 5) != 0;
      srcTick = 4'hF;
      srcTick[sel] = s;
      if (s) cnt++;
      #1 check(req, {31'd0, tickOut}, {31'd0, (s && (cnt % ratio == 0))});
      @(negedge clk);
    end
    srcTick = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset word and pass-through of source 0
    check("R1 reset word", cfgRdData, 32'h0);
    srcTick = 4'b0001; #1 check("R1 follow src0", {31'd0, tickOut}, 32'd1);
    @(negedge clk);
    srcTick = 4'b1110; #1 check("R1 other src", {31'd0, tickOut}, 32'd0);
    @(negedge clk);
    srcTick = '0;

    // R2 R3 R4 R5 R6: table walk
    for (int v = 0; v < NV; v++) begin
      int sel, pre, post, ratio;
      sel = VEC[v][8:7]; pre = VEC[v][6:2]; post = VEC[v][1:0];
      ratio = (sel == 3) ? (pre + 1) * (post + 1) : (post + 1);
      cfgWrite({14'd0, sel[1:0], 3'd0, pre[4:0], 2'd0, post[1:0], 4'd0},
               32'h0003_1F30, 4'h0, 1'b0, "R9 write quiet");
      check("R2 readback", cfgRdData & 32'h0003_1F30,
            {14'd0, sel[1:0], 3'd0, pre[4:0], 2'd0, post[1:0], 4'd0});
      cnt = 0;
      run(sel, ratio, 3 * ratio + 10, cnt, sel == 3 ? "R6 cascade" : "R5 R3 direct");
    end

    // R7: masked write of pre field only keeps sel and post
    cfgWrite(32'h0000_0000, 32'hFFFF_FFFF, 4'h0, 1'b0, "R9 clear");
    cfgWrite(32'h0003_0020, 32'h0003_0030, 4'h0, 1'b0, "R7 setup");
    cfgWrite(32'hFFFF_07FF, 32'h0000_1F00, 4'h0, 1'b0, "R7 pre only");
    check("R7 merged word", cfgRdData, 32'h0003_0720);

    // R8: unused bits mid-period do not restart; R4 with pre=7 post=2 ratio 24
    cnt = 0;
    run(3, 24, 30, cnt, "R4 pre active");
    cfgWrite(32'hA5A0_00C0, 32'hFFFC_E0CF, 4'h0, 1'b0, "R8 unused write");
    check("R8 readback", cfgRdData, 32'hA5A3_07E0);
    run(3, 24, 40, cnt, "R8 period continues");

    // R9: field write with a coinciding selected strobe restarts
    cfgWrite(32'h0000_0010, 32'h0000_0030, 4'b1000, 1'b0, "R9 strobe in write");
    cnt = 0;
    run(3, 16, 40, cnt, "R9 restart spacing");

    // R10: output strobe is one cycle wide with a held source
    cfgWrite(32'h0000_0000, 32'h0003_1F30, 4'h0, 1'b0, "R9 to src0");
    srcTick = 4'b0001;
    #1 check("R10 width a", {31'd0, tickOut}, 32'd1);
    @(negedge clk); srcTick = 4'b0000;
    #1 check("R10 width b", {31'd0, tickOut}, 32'd0);
    @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule